// File: doc/BRIEF.md
# Shader Condition-Code Branch Unit

This unit sequences the program counter of a vector shader whose programs hold up to 256 instructions. It keeps a four-lane condition-code register that instructions may refresh from their result lanes. It evaluates a condition test on every flow instruction, and it performs direct, computed and conditional jumps, as well as subroutine call and return through a four-entry return stack. It also caps the number of instructions one vertex may execute. Arithmetic lives elsewhere. Each result lane reaches the unit only as three flags: negative, zero and not-a-number. The decoder supplies the control fields of the instruction.

The instruction stream is a valid/ready interface. `in_ready` equals `run`, so it is high for the whole time a vertex is active. An instruction transfers on a clock edge where `in_valid` and `in_ready` are both high. It must be the instruction stored at the `pc` the unit currently shows. While `in_valid` is low, the unit waits and nothing changes. While `in_ready` is low, the upstream side must hold its instruction back; an instruction offered then is not accepted. A one-cycle `start` begins a vertex at address 0. The vertex ends with a one-cycle `done` pulse, and the two sticky error flags tell a faulty end apart from a normal one.

Top module: `shader_branch_unit`

## Requirements
- R1: After reset, `run`, `in_ready`, `done`, `err_stack` and `err_target` are 0, and `cc` reads 8'h55 (every lane EQ). A `start` pulse sets `pc` to 0, raises `run` and `in_ready`, and clears the errors, the return stack, the executed count and the condition codes (back to 8'h55).
- R2: An accepted instruction that does not redirect flow advances `pc` by one. While no instruction is accepted, `pc` stays put. An instruction offered while `in_ready` is low changes neither `pc` nor `done`.
- R3: Lane i of the condition codes sits at `cc[2i+1:2i]`, encoded LT=0, EQ=1, GT=2, UN=3. When an accepted instruction has `in_ccupd`=1, each lane takes UN if its nan flag is set; otherwise EQ if its zero flag is set; otherwise LT if its neg flag is set; otherwise GT. When `in_ccupd`=0, the codes are unchanged.
- R4: `in_rel` holds the relation: 0 FL, 1 LT, 2 EQ, 3 LE, 4 GT, 5 NE, 6 GE, 7 TR. On a lane whose code is UN, only NE and TR hold. FL never holds, and TR always does.
- R5: Test lane i reads the condition-code lane named by `in_swz[2i+1:2i]`. The condition holds if the relation holds on any of the four test lanes.
- R6: `in_op` holds the operation: 0 plain, 1 branch, 2 call, 3 return. A branch whose condition holds loads `pc` from `in_target` when `in_indirect`=0.
- R7: When `in_indirect`=1, a branch or call takes its target from the signed lane `in_areg[16k+15:16k]`, where k is `in_asel`. If that value lies outside 0..255 and the condition holds, the vertex ends and `err_target` is set. If the condition fails, the value is ignored.
- R8: A call whose condition holds pushes the address after itself and jumps to its target. A return whose condition holds jumps to the most recently pushed address and removes it. A return whose condition fails advances by one.
- R9: The return stack holds four entries. A call whose condition holds, made while four addresses are stacked, sets `err_stack` and ends the vertex. A return whose condition holds, made on an empty stack, ends the vertex without an error.
- R10: The instruction that brings the executed count to MAX_EXEC ends the vertex.
- R11: A step past address 255, whether by falling through or by returning to the address after a call placed at 255, ends the vertex without an error.
- R12: An ending instruction drops `run` and raises `done` at the same clock edge that accepts it. `done` then stays high for exactly one cycle. The error flags stay set until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a vertex at address 0 |
| in_valid | input | 1 | Instruction for `pc` is presented |
| in_ready | output | 1 | Unit accepts an instruction (equals `run`) |
| in_op | input | 2 | Operation: plain, branch, call, return |
| in_rel | input | 3 | Condition relation |
| in_swz | input | 8 | Condition-lane swizzle, 2 bits per test lane |
| in_indirect | input | 1 | Target comes from the address register |
| in_target | input | 8 | Direct target address |
| in_asel | input | 2 | Address-register lane select |
| in_areg | input | 64 | Four signed 16-bit address-register lanes |
| in_ccupd | input | 1 | Refresh the condition codes from the result flags |
| in_neg | input | 4 | Per-lane result negative |
| in_zero | input | 4 | Per-lane result zero |
| in_nan | input | 4 | Per-lane result not-a-number |
| pc | output | 8 | Address of the instruction requested next |
| run | output | 1 | Vertex active |
| done | output | 1 | One-cycle vertex-end pulse |
| err_stack | output | 1 | Sticky: call made with a full stack |
| err_target | output | 1 | Sticky: computed target out of range |
| cc | output | 8 | Condition-code lanes |

## Verification
The condition test is swept over all eight relations against all four codes, with every lane holding the same code. This separates each relation's truth table, UN included. A second sweep places a single GT lane at each of the four positions and points the swizzle at each lane in turn, which shows whether lanes are selected and combined by any-match. All eight combinations of the neg, zero and nan flags are applied, which pins down their priority. Directed sequences then nest calls four deep and unwind them, overflow and underflow the stack, supply computed targets in range, below 0 and above 255, and run the executed-instruction limit out. In each case the check separates a normal end from a faulty one.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  typedef enum logic [1:0] {CC_LT = 2'd0, CC_EQ = 2'd1, CC_GT = 2'd2, CC_UN = 2'd3} cc_code_e;
  typedef enum logic [1:0] {OP_ALU = 2'd0, OP_BRA = 2'd1, OP_CAL = 2'd2, OP_RET = 2'd3} flow_op_e;

  localparam logic [2:0] REL_NE = 3'd5;
  localparam logic [2:0] REL_TR = 3'd7;

  // Relation bits: bit0 accepts LT, bit1 accepts EQ, bit2 accepts GT.
  function automatic logic rel_holds(input logic [2:0] rel, input logic [1:0] code);
    if (code == CC_UN) return (rel == REL_NE) || (rel == REL_TR);
    return rel[code];
  endfunction

  function automatic logic [1:0] classify(input logic neg, input logic zero, input logic nan);
    if (nan)  return CC_UN;
    if (zero) return CC_EQ;
    if (neg)  return CC_LT;
    return CC_GT;
  endfunction
endpackage

// File: rtl/sbu_cc_unit.sv
module sbu_cc_unit
  import sbu_pkg::*;
#(
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    upd_en,
  input  logic [LANES-1:0]        neg,
  input  logic [LANES-1:0]        zero,
  input  logic [LANES-1:0]        nan,
  input  logic [2:0]              rel,
  input  logic [LANES*SEL_W-1:0]  swz,
  output logic [2*LANES-1:0]      cc,
  output logic                    hit
);
  logic [1:0] lane_q [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lane_q[i] <= CC_EQ;
      else if (clear)  lane_q[i] <= CC_EQ;
      else if (upd_en) lane_q[i] <= classify(neg[i], zero[i], nan[i]);
    end
    assign cc[2*i +: 2] = lane_q[i];
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (rel_holds(rel, lane_q[swz[SEL_W*i +: SEL_W]])) hit = 1'b1;
  end

  // R3
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !clear) |=> $stable(cc));

  // R1
  cc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cc == {LANES{2'(CC_EQ)}}));
endmodule

// File: rtl/sbu_ret_stack.sv
module sbu_ret_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 9,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  logic [CW-1:0] cnt;
  logic [W-1:0]  mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (push)  cnt <= cnt + CW'(1);
    else if (pop)   cnt <= cnt - CW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mem[i] <= '0;
      else if (push && !clear && cnt == CW'(i))     mem[i] <= push_data;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cnt == CW'(i + 1)) top = mem[i];
  end

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sbu_exec_limit.sv
module sbu_exec_limit #(
  parameter int MAX_EXEC = 65536,
  localparam int CW = $clog2(MAX_EXEC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (inc)   cnt <= cnt + CW'(1);
  end

  assign last = inc && (cnt == CW'(MAX_EXEC - 1));

  // R10
  exec_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_EXEC));
endmodule

// File: rtl/shader_branch_unit.sv
module shader_branch_unit
  import sbu_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int PC_W        = 8,
  parameter int STACK_DEPTH = 4,
  parameter int AREG_W      = 16,
  parameter int MAX_EXEC    = 65536,
  localparam int SEL_W      = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              in_op,
  input  logic [2:0]              in_rel,
  input  logic [LANES*SEL_W-1:0]  in_swz,
  input  logic                    in_indirect,
  input  logic [PC_W-1:0]         in_target,
  input  logic [SEL_W-1:0]        in_asel,
  input  logic [LANES*AREG_W-1:0] in_areg,
  input  logic                    in_ccupd,
  input  logic [LANES-1:0]        in_neg,
  input  logic [LANES-1:0]        in_zero,
  input  logic [LANES-1:0]        in_nan,
  output logic [PC_W-1:0]         pc,
  output logic                    run,
  output logic                    done,
  output logic                    err_stack,
  output logic                    err_target,
  output logic [2*LANES-1:0]      cc
);
  localparam logic signed [AREG_W-1:0] TGT_MAX = AREG_W'((1 << PC_W) - 1);

  logic              accept, hit, st_empty, st_full, lim_last;
  logic              push, pop, fin, set_et, set_es, end_now, ind_bad;
  logic [PC_W:0]     seq, nxt, st_top;
  logic [PC_W-1:0]   tgt;
  logic signed [AREG_W-1:0] ind_val;

  assign in_ready = run;
  assign accept   = in_valid && run;

  sbu_cc_unit #(.LANES(LANES)) u_cc (
    .clk(clk), .rst_n(rst_n), .clear(start), .upd_en(accept && in_ccupd),
    .neg(in_neg), .zero(in_zero), .nan(in_nan), .rel(in_rel), .swz(in_swz),
    .cc(cc), .hit(hit)
  );

  sbu_ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W + 1)) u_stack (
    .clk(clk), .rst_n(rst_n), .clear(start), .push(push), .pop(pop),
    .push_data(seq), .top(st_top), .empty(st_empty), .full(st_full)
  );

  sbu_exec_limit #(.MAX_EXEC(MAX_EXEC)) u_limit (
    .clk(clk), .rst_n(rst_n), .clear(start), .inc(accept), .last(lim_last)
  );

  assign ind_val = in_areg[AREG_W*in_asel +: AREG_W];
  assign ind_bad = in_indirect && (ind_val[AREG_W-1] || (ind_val > TGT_MAX));
  assign tgt     = in_indirect ? ind_val[PC_W-1:0] : in_target;
  assign seq     = {1'b0, pc} + (PC_W+1)'(1);

  always_comb begin
    nxt = seq; push = 1'b0; pop = 1'b0; fin = 1'b0; set_et = 1'b0; set_es = 1'b0;
    if (accept && hit) begin
      case (flow_op_e'(in_op))
        OP_BRA: begin
          if (ind_bad) set_et = 1'b1;
          else         nxt = {1'b0, tgt};
        end
        OP_CAL: begin
          set_et = ind_bad;
          set_es = st_full;
          if (!ind_bad && !st_full) begin
            push = 1'b1;
            nxt  = {1'b0, tgt};
          end
        end
        OP_RET: begin
          if (st_empty) fin = 1'b1;
          else begin
            pop = 1'b1;
            nxt = st_top;
          end
        end
        default: ;
      endcase
    end
  end

  assign end_now = accept && (fin || set_et || set_es || nxt[PC_W] || lim_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; run <= 1'b0; done <= 1'b0; err_stack <= 1'b0; err_target <= 1'b0;
    end else if (start) begin
      pc <= '0; run <= 1'b1; done <= 1'b0; err_stack <= 1'b0; err_target <= 1'b0;
    end else begin
      done <= end_now;
      if (accept) begin
        pc <= nxt[PC_W-1:0];
        if (end_now) run <= 1'b0;
        if (set_es) err_stack  <= 1'b1;
        if (set_et) err_target <= 1'b1;
      end
    end
  end

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !start) |=> $stable(pc));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  run_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> done);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_stack || err_target) && !start) |=> (err_stack || err_target));
endmodule

// File: tb/shader_branch_unit_bench.sv
`timescale 1ns/100ps
module shader_branch_unit_bench;
  localparam int LIM = 20;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic [2:0]  in_rel = 3'd0;
  logic [7:0]  in_swz = 8'hE4;
  logic        in_indirect = 1'b0;
  logic [7:0]  in_target = 8'd0;
  logic [1:0]  in_asel = 2'd0;
  logic [63:0] in_areg = '0;
  logic        in_ccupd = 1'b0;
  logic [3:0]  in_neg = '0, in_zero = '0, in_nan = '0;
  logic [7:0]  pc, cc;
  logic        run, done, err_stack, err_target;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shader_branch_unit #(.MAX_EXEC(LIM)) u_shader_branch_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rel(in_rel), .in_swz(in_swz), .in_indirect(in_indirect),
    .in_target(in_target), .in_asel(in_asel), .in_areg(in_areg), .in_ccupd(in_ccupd),
    .in_neg(in_neg), .in_zero(in_zero), .in_nan(in_nan), .pc(pc), .run(run),
    .done(done), .err_stack(err_stack), .err_target(err_target), .cc(cc)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic send(input logic [1:0] op, input logic [2:0] rel, input logic [7:0] swz,
                      input logic ind, input logic [7:0] tgt);
    @(negedge clk);
    in_op = op; in_rel = rel; in_swz = swz; in_indirect = ind; in_target = tgt;
    in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0; in_ccupd = 1'b0;
  endtask

  task automatic set_cc(input logic [3:0] n, input logic [3:0] z, input logic [3:0] q);
    in_neg = n; in_zero = z; in_nan = q; in_ccupd = 1'b1;
    send(2'd0, 3'd0, 8'hE4, 1'b0, 8'd0);
  endtask

  // Expected truth of a relation on one code, from the relation table.
  function automatic bit exp_rel(input int rel, input int code);
    case (rel)
      0: return 0;
      1: return code == 0;
      2: return code == 1;
      3: return code == 0 || code == 1;
      4: return code == 2;
      5: return code != 1;
      6: return code == 1 || code == 2;
      default: return 1;
    endcase
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 run", run, 0); chk("R1 ready", in_ready, 0); chk("R1 done", done, 0);
    chk("R1 err_stack", err_stack, 0); chk("R1 err_target", err_target, 0);
    chk("R1 cc", cc, 8'h55);
    @(negedge clk); rst_n = 1'b1;

    do_start();
    chk("R1 pc", pc, 0); chk("R1 run after start", run, 1); chk("R1 ready after start", in_ready, 1);

    // R2 idle holds, step advances
    repeat (3) @(posedge clk);
    #1 chk("R2 hold", pc, 0);
    send(2'd0, 3'd7, 8'hE4, 1'b0, 8'd9);
    chk("R2 step", pc, 1);

    // R3 flag priority sweep
    for (int f = 0; f < 8; f++) begin
      int code;
      code = f[2] ? 3 : (f[1] ? 1 : (f[0] ? 0 : 2));
      set_cc({4{f[0]}}, {4{f[1]}}, {4{f[2]}});
      chk("R3 class", cc, code * 8'h55);
    end
    do_start();
    set_cc(4'b0110, 4'b0011, 4'b0001);
    chk("R3 mixed", cc, 8'h87);
    in_neg = 4'hF; in_zero = 4'h0; in_nan = 4'h0;
    send(2'd0, 3'd0, 8'hE4, 1'b0, 8'd0);
    chk("R3 no update", cc, 8'h87);
    do_start();
    chk("R1 cc cleared", cc, 8'h55);

    // R4 and R6: relation x code sweep with uniform lanes
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 4; c++) begin
        do_start();
        set_cc({4{c == 0}}, {4{c == 1}}, {4{c == 3}});
        send(2'd1, 3'(r), 8'hE4, 1'b0, 8'd40);
        chk("R4 R6 branch", pc, exp_rel(r, c) ? 40 : 2);
      end
    end

    // R5 swizzle: one GT lane j, test lanes all pointing at lane s
    for (int j = 0; j < 4; j++) begin
      for (int s = 0; s < 4; s++) begin
        do_start();
        set_cc(4'h0, ~(4'b1 << j), 4'h0);
        send(2'd1, 3'd4, {4{2'(s)}}, 1'b0, 8'd33);
        chk("R5 swizzle", pc, (s == j) ? 33 : 2);
      end
    end
    do_start();
    set_cc(4'b0100, 4'h0, 4'h0);            // x GT, y GT, z LT, w GT
    send(2'd1, 3'd3, 8'hF4, 1'b0, 8'd50);   // LE over x y w w
    chk("R5 xyww miss", pc, 2);
    send(2'd1, 3'd3, 8'hA4, 1'b0, 8'd50);   // LE over x y z z
    chk("R5 xyzz hit", pc, 50);

    // R7 computed targets: lanes 300, 100, -1, 255
    in_areg = {16'd255, 16'hFFFF, 16'd100, 16'd300};
    do_start();
    in_asel = 2'd1; send(2'd1, 3'd7, 8'hE4, 1'b1, 8'd7);
    chk("R7 indirect", pc, 100);
    in_asel = 2'd2; send(2'd1, 3'd0, 8'hE4, 1'b1, 8'd7);
    chk("R7 untaken bad pc", pc, 101); chk("R7 untaken no err", err_target, 0);
    in_asel = 2'd3; send(2'd1, 3'd7, 8'hE4, 1'b1, 8'd7);
    chk("R7 edge 255", pc, 255);
    send(2'd0, 3'd7, 8'hE4, 1'b0, 8'd0);
    chk("R11 fall end done", done, 1); chk("R11 run", run, 0); chk("R11 no err", err_target, 0);
    do_start();
    in_asel = 2'd2; send(2'd1, 3'd7, 8'hE4, 1'b1, 8'd7);
    chk("R7 negative err", err_target, 1); chk("R7 negative done", done, 1); chk("R7 run", run, 0);
    @(posedge clk); #1;
    chk("R12 done one cycle", done, 0); chk("R12 sticky", err_target, 1);
    do_start();
    chk("R12 clear on start", err_target, 0);
    in_asel = 2'd0; send(2'd2, 3'd7, 8'hE4, 1'b1, 8'd7);
    chk("R7 high err", err_target, 1); chk("R7 high run", run, 0);

    // R8 R9 nesting and unwinding
    do_start();
    in_asel = 2'd1; send(2'd2, 3'd7, 8'hE4, 1'b1, 8'd0);
    chk("R8 indirect call", pc, 100);
    send(2'd3, 3'd0, 8'hE4, 1'b0, 8'd0);
    chk("R8 return untaken", pc, 101);
    send(2'd3, 3'd7, 8'hE4, 1'b0, 8'd0);
    chk("R8 return", pc, 1);
    do_start();
    for (int k = 0; k < 4; k++) begin
      send(2'd2, 3'd7, 8'hE4, 1'b0, 8'(50 + 10 * k));
      chk("R8 call", pc, 50 + 10 * k);
    end
    for (int k = 3; k >= 0; k--) begin
      send(2'd3, 3'd7, 8'hE4, 1'b0, 8'd0);
      chk("R8 unwind", pc, (k == 0) ? 1 : 51 + 10 * (k - 1));
    end
    send(2'd3, 3'd7, 8'hE4, 1'b0, 8'd0);
    chk("R9 empty return done", done, 1); chk("R9 empty no err", err_stack, 0);
    chk("R9 empty run", run, 0);
    do_start();
    for (int k = 0; k < 4; k++) send(2'd2, 3'd7, 8'hE4, 1'b0, 8'(50 + 10 * k));
    chk("R9 four deep run", run, 1);
    send(2'd2, 3'd7, 8'hE4, 1'b0, 8'd200);
    chk("R9 overflow err", err_stack, 1); chk("R9 overflow done", done, 1);
    chk("R9 overflow run", run, 0);

    // R11 call at 255 returns to 256
    do_start();
    send(2'd1, 3'd7, 8'hE4, 1'b0, 8'd255);
    send(2'd2, 3'd7, 8'hE4, 1'b0, 8'd10);
    chk("R11 call from 255", pc, 10);
    send(2'd3, 3'd7, 8'hE4, 1'b0, 8'd0);
    chk("R11 return to 256 done", done, 1); chk("R11 return err", err_stack, 0);

    // R10 limit
    do_start();
    for (int k = 0; k < LIM - 1; k++) send(2'd1, 3'd7, 8'hE4, 1'b0, 8'd0);
    chk("R10 before limit", run, 1); chk("R10 before done", done, 0);
    send(2'd1, 3'd7, 8'hE4, 1'b0, 8'd0);
    chk("R10 limit done", done, 1); chk("R10 limit run", run, 0);
    // R2 offer while not ready is ignored
    send(2'd0, 3'd7, 8'hE4, 1'b0, 8'd0);
    chk("R2 not ready pc", pc, 0); chk("R2 not ready done", done, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule